// File: doc/BRIEF.md
# Tiny RV32I Core for Runtime-Generated Code

A multicycle processor core that executes a deliberately small slice of the 32-bit RISC-V base integer set out of a single word-addressed memory that holds both code and data. It is built for copy-then-jump programs: a routine copies instruction words from a data area into a code buffer with word stores, jumps into the buffer with a register jump, and the newly written words are fetched and run. A store is visible to the next instruction fetch with no flush or fence.

The core decodes only the immediate ALU group (add, exclusive-or, or), word loads and stores, the register jump, add-upper-immediate-to-pc and the SYSTEM opcode. Anything outside that set stops the core and flags a fault together with the address of the offending word. Environment calls are reported on a small output port. Service code 10 halts the core. Running off the end of the code region also halts it.

Top module: `jit_core`

## Requirements
- R1: Opcode 0010011 with funct3 000, 100 or 110 writes rd with rs1 plus, xor or or the 12-bit immediate from bits 31:20, sign-extended from bit 31 (so 0x02a00513, 0x02a04513 and 0x02a06513 each leave 42 in x10).
- R2: A funct3 that the core does not support (0010011 with anything other than 000/100/110, load or store with anything other than 010, register jump with anything other than 000) sets fault_o and sets fault_pc_o to that instruction's byte address; both stay put until reset.
- R3: An opcode outside the supported set (for example 0x00000000 or an R-type word) sets fault_o with the instruction address; fault_o and halt_o are never high together.
- R4: Register x0 reads as zero after any write aimed at it.
- R5: The register jump (opcode 1100111) goes to rs1 plus the sign-extended immediate with bit 0 cleared and writes the address of the next instruction into rd.
- R6: Opcode 0010111 writes rd with the address of that instruction plus bits 31:12 shifted left by 12.
- R7: Word load (0000011) and word store (0100011) use rs1 plus a sign-extended immediate; the store immediate is bits 31:25 above bits 11:7. A stored word is the one fetched by a later fetch of that address, and a single cycle never both reads and writes memory.
- R8: The word 0x00100073 does nothing; every other SYSTEM word (opcode 1110011) pulses ecall_valid_o for one cycle with ecall_code_o holding x17 and ecall_arg_o holding x10.
- R9: An environment call whose code is 10 raises halt_o in the same cycle as its pulse; halt_o stays high and the core makes no further memory access or call.
- R10: When the fetch address reaches CODE_BYTES the core halts with no fault and no call.
- R11: While reset is held, halt_o, fault_o, ecall_valid_o and mem_we_o are low; after release the first fetch reads address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Byte address for fetch, load or store |
| mem_re_o | output | 1 | Read request; data returned on mem_rdata_i one cycle later |
| mem_we_o | output | 1 | Word write strobe |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after mem_re_o |
| ecall_valid_o | output | 1 | One-cycle environment-call pulse |
| ecall_code_o | output | 32 | Service code (x17) |
| ecall_arg_o | output | 32 | Argument (x10) |
| halt_o | output | 1 | Sticky halt |
| fault_o | output | 1 | Sticky illegal-instruction flag |
| fault_pc_o | output | 32 | Address of the faulting instruction |

## Verification
The copy-then-jump program is run with the three known 42-producing words, then with many random generated words that mix the three ALU functions, negative and positive immediates, x0 or a preloaded x10 as source, and an odd jump offset. A wrong function select, wrong sign extension or stale fetch each gives a different returned argument. Short directed programs separate x0 handling, the upper-immediate address arithmetic with both signs, each fault kind at a known address, and the code-limit halt from the service-code halt.

// File: rtl/jit_pkg.sv
package jit_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned RIDX = 5;

  localparam logic [6:0] OP_ALUI  = 7'b0010011;
  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_JALR  = 7'b1100111;
  localparam logic [6:0] OP_AUIPC = 7'b0010111;
  localparam logic [6:0] OP_SYS   = 7'b1110011;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_XOR  = 3'b100;
  localparam logic [2:0] F3_OR   = 3'b110;
  localparam logic [2:0] F3_WORD = 3'b010;

  localparam logic [XLEN-1:0] WORD_BRK = 32'h0010_0073;
  localparam logic [RIDX-1:0] REG_SVC  = 5'd17;
  localparam logic [RIDX-1:0] REG_ARG  = 5'd10;

  typedef enum logic [2:0] {
    K_ALU, K_LOAD, K_STORE, K_JALR, K_AUIPC, K_NOP, K_ECALL, K_BAD
  } kind_e;

  typedef enum logic [2:0] {
    S_FETCH, S_WAIT, S_EXEC, S_LOAD, S_STOP
  } state_e;

  typedef struct packed {
    kind_e           kind;
    logic [RIDX-1:0] rd;
    logic [RIDX-1:0] ra;
    logic [RIDX-1:0] rb;
    logic [2:0]      f3;
    logic [XLEN-1:0] imm;
  } dec_t;
endpackage

// File: rtl/jit_decode.sv
module jit_decode
  import jit_pkg::*;
(
  input  logic [XLEN-1:0] ir_i,
  output dec_t            dec_o
);
  logic [6:0]      opc;
  logic [XLEN-1:0] imm_i, imm_s, imm_u;

  assign opc   = ir_i[6:0];
  assign imm_i = {{(XLEN-12){ir_i[31]}}, ir_i[31:20]};
  assign imm_s = {{(XLEN-12){ir_i[31]}}, ir_i[31:25], ir_i[11:7]};
  assign imm_u = {ir_i[31:12], 12'b0};

  always_comb begin
    dec_o.rd   = ir_i[11:7];
    dec_o.ra   = ir_i[19:15];
    dec_o.rb   = ir_i[24:20];
    dec_o.f3   = ir_i[14:12];
    dec_o.imm  = imm_i;
    dec_o.kind = K_BAD;
    unique case (opc)
      OP_ALUI: begin
        if (ir_i[14:12] == F3_ADD || ir_i[14:12] == F3_XOR || ir_i[14:12] == F3_OR)
          dec_o.kind = K_ALU;
      end
      OP_LOAD: begin
        if (ir_i[14:12] == F3_WORD) dec_o.kind = K_LOAD;
      end
      OP_STORE: begin
        dec_o.imm = imm_s;
        if (ir_i[14:12] == F3_WORD) dec_o.kind = K_STORE;
      end
      OP_JALR: begin
        if (ir_i[14:12] == 3'b000) dec_o.kind = K_JALR;
      end
      OP_AUIPC: begin
        dec_o.imm  = imm_u;
        dec_o.kind = K_AUIPC;
      end
      OP_SYS: begin
        // call port reads service code and argument registers
        dec_o.ra   = REG_SVC;
        dec_o.rb   = REG_ARG;
        dec_o.kind = (ir_i == WORD_BRK) ? K_NOP : K_ECALL;
      end
      default: dec_o.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/jit_regfile.sv
module jit_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] qa_o,
  output logic [DW-1:0] qb_o
);
  // no storage for x0
  logic [DW-1:0] regs_q [1:NREG-1];

  always_ff @(posedge clk_i) begin
    if (we_i && wa_i != '0) regs_q[wa_i] <= wd_i;
  end

  assign qa_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign qb_o = (rb_i == '0) ? '0 : regs_q[rb_i];
endmodule

// File: rtl/jit_exec.sv
module jit_exec
  import jit_pkg::*;
(
  input  dec_t            dec_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs_a_i,
  output logic [XLEN-1:0] result_o,
  output logic [XLEN-1:0] ea_o,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o
);
  assign ea_o     = rs_a_i + dec_i.imm;
  assign target_o = {ea_o[XLEN-1:1], 1'b0};
  assign link_o   = pc_i + XLEN'(4);

  always_comb begin
    result_o = '0;
    unique case (dec_i.kind)
      K_ALU: begin
        unique case (dec_i.f3)
          F3_XOR:  result_o = rs_a_i ^ dec_i.imm;
          F3_OR:   result_o = rs_a_i | dec_i.imm;
          default: result_o = rs_a_i + dec_i.imm;
        endcase
      end
      K_AUIPC: result_o = pc_i + dec_i.imm;
      K_JALR:  result_o = link_o;
      default: result_o = '0;
    endcase
  end
endmodule

// File: rtl/jit_core.sv
module jit_core
  import jit_pkg::*;
#(
  parameter int unsigned     CODE_BYTES = 256,
  parameter int unsigned     NREG       = 32,
  parameter logic [XLEN-1:0] HALT_SVC   = 32'd10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic            mem_re_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            ecall_valid_o,
  output logic [XLEN-1:0] ecall_code_o,
  output logic [XLEN-1:0] ecall_arg_o,
  output logic            halt_o,
  output logic            fault_o,
  output logic [XLEN-1:0] fault_pc_o
);
  localparam int unsigned     RAW      = $clog2(NREG);
  localparam logic [XLEN-1:0] CODE_END = XLEN'(CODE_BYTES);

  state_e          st_q;
  logic [XLEN-1:0] pc_q, ir_q, fpc_q, ecode_q, earg_q;
  logic            halt_q, fault_q, ev_q;

  dec_t            dec;
  logic [XLEN-1:0] rs_a, rs_b, result, ea, target, link;
  logic            wr_en;
  logic [XLEN-1:0] wr_dat;

  jit_decode u_dec (.ir_i(ir_q), .dec_o(dec));

  jit_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
    .clk_i (clk_i),
    .we_i  (wr_en),
    .wa_i  (dec.rd[RAW-1:0]),
    .wd_i  (wr_dat),
    .ra_i  (dec.ra[RAW-1:0]),
    .rb_i  (dec.rb[RAW-1:0]),
    .qa_o  (rs_a),
    .qb_o  (rs_b)
  );

  jit_exec u_exe (
    .dec_i    (dec),
    .pc_i     (pc_q),
    .rs_a_i   (rs_a),
    .result_o (result),
    .ea_o     (ea),
    .target_o (target),
    .link_o   (link)
  );

  assign wr_en  = (st_q == S_LOAD) ||
                  (st_q == S_EXEC && (dec.kind == K_ALU || dec.kind == K_AUIPC ||
                                      dec.kind == K_JALR));
  assign wr_dat = (st_q == S_LOAD) ? mem_rdata_i : result;

  assign mem_re_o    = (st_q == S_FETCH && pc_q < CODE_END) ||
                       (st_q == S_EXEC && dec.kind == K_LOAD);
  assign mem_we_o    = (st_q == S_EXEC && dec.kind == K_STORE);
  assign mem_addr_o  = (st_q == S_FETCH) ? pc_q : ea;
  assign mem_wdata_o = rs_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      halt_q  <= 1'b0;
      fault_q <= 1'b0;
      fpc_q   <= '0;
      ev_q    <= 1'b0;
      ecode_q <= '0;
      earg_q  <= '0;
    end else begin
      ev_q <= 1'b0;
      unique case (st_q)
        S_FETCH: begin
          if (pc_q >= CODE_END) begin
            halt_q <= 1'b1;
            st_q   <= S_STOP;
          end else begin
            st_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          ir_q <= mem_rdata_i;
          st_q <= S_EXEC;
        end
        S_EXEC: begin
          unique case (dec.kind)
            K_ALU, K_AUIPC, K_NOP, K_STORE: begin
              pc_q <= link;
              st_q <= S_FETCH;
            end
            K_LOAD: st_q <= S_LOAD;
            K_JALR: begin
              pc_q <= target;
              st_q <= S_FETCH;
            end
            K_ECALL: begin
              ev_q    <= 1'b1;
              ecode_q <= rs_a;
              earg_q  <= rs_b;
              pc_q    <= link;
              if (rs_a == HALT_SVC) begin
                halt_q <= 1'b1;
                st_q   <= S_STOP;
              end else begin
                st_q <= S_FETCH;
              end
            end
            default: begin
              fault_q <= 1'b1;
              fpc_q   <= pc_q;
              st_q    <= S_STOP;
            end
          endcase
        end
        S_LOAD: begin
          pc_q <= link;
          st_q <= S_FETCH;
        end
        default: st_q <= S_STOP;
      endcase
    end
  end

  assign ecall_valid_o = ev_q;
  assign ecall_code_o  = ecode_q;
  assign ecall_arg_o   = earg_q;
  assign halt_o        = halt_q;
  assign fault_o       = fault_q;
  assign fault_pc_o    = fpc_q;

  p_rw_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  p_call_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecall_valid_o |=> !ecall_valid_o);

  p_halt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  p_quiet_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o || fault_o) |-> (!mem_re_o && !mem_we_o));

  p_fault_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (fault_o && $stable(fault_pc_o)));

  p_halt_xor_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_o && fault_o));
endmodule

// File: tb/sim_jit_core.sv
module sim_jit_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;
  localparam int LIMIT      = 256;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, ec_code_w, ec_arg_w, fpc;
  logic [31:0] mem_rdata = '0;
  logic        mem_re, mem_we, ec_valid, halt, fault;

  jit_core #(.CODE_BYTES(LIMIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .ecall_valid_o(ec_valid), .ecall_code_o(ec_code_w), .ecall_arg_o(ec_arg_w),
    .halt_o(halt), .fault_o(fault), .fault_pc_o(fpc)
  );

  logic [31:0] mem [0:MEM_WORDS-1];
  logic [31:0] img [0:MEM_WORDS-1];
  logic        ld_en = 1'b0;
  logic [5:0]  ld_idx = '0;
  logic [31:0] ld_dat = '0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_dat;
    else if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:2]];
  end

  logic        cap_clr = 1'b1;
  int          n_ec = 0;
  logic [31:0] cap_code [0:3];
  logic [31:0] cap_arg  [0:3];
  always @(negedge clk) begin
    if (cap_clr) n_ec <= 0;
    else if (ec_valid) begin
      cap_code[n_ec[1:0]] <= ec_code_w;
      cap_arg[n_ec[1:0]]  <= ec_arg_w;
      n_ec <= n_ec + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_i(input logic [11:0] imm, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] f_s(input logic [11:0] imm, input logic [4:0] rs2,
                                      input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] f_u(input logic [19:0] imm, input logic [4:0] rd);
    return {imm, rd, 7'b0010111};
  endfunction
  function automatic logic [31:0] sx(input logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction
  function automatic logic [31:0] calc(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
    case (f3)
      3'b100:  return a ^ b;
      3'b110:  return a | b;
      default: return a + b;
    endcase
  endfunction

  task automatic fill_nop();
    for (int i = 0; i < MEM_WORDS; i++) img[i] = NOP;
  endtask

  // appends: a7=1, call, a7=10, call
  task automatic tail_at(input int i);
    img[i]   = f_i(12'd1, 5'd0, 3'd0, 5'd17, 7'h13);
    img[i+1] = 32'h0000_0073;
    img[i+2] = f_i(12'd10, 5'd0, 3'd0, 5'd17, 7'h13);
    img[i+3] = 32'h0000_0073;
  endtask

  task automatic run(input bit chk_reset);
    rst_n   = 1'b0;
    cap_clr = 1'b1;
    for (int i = 0; i < MEM_WORDS; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = i[5:0]; ld_dat = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    if (chk_reset) begin
      chk(!halt && !fault, "R11 status low in reset", {30'b0, halt, fault}, 32'h0);
      chk(!ec_valid && !mem_we, "R11 no call or write in reset", {30'b0, ec_valid, mem_we}, 32'h0);
    end
    rst_n   = 1'b1;
    cap_clr = 1'b0;
    #1;
    if (chk_reset)
      chk(mem_re && mem_addr == 32'h0, "R11 first fetch at 0", mem_addr, 32'h0);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (halt || fault) break;
    end
    if (!(halt || fault)) chk(1'b0, "watchdog run", 32'h0, 32'h1);
    repeat (4) @(negedge clk);
  endtask

  task automatic build_jit(input logic [31:0] w0, input logic [11:0] pre, input bit odd);
    fill_nop();
    img[0]  = f_u(20'h0, 5'd5);
    img[1]  = f_i(12'd128, 5'd5, 3'd0, 5'd5, 7'h13);
    img[2]  = f_u(20'h0, 5'd6);
    img[3]  = f_i(12'd104, 5'd6, 3'd0, 5'd6, 7'h13);
    img[4]  = f_i(12'd0, 5'd5, 3'b010, 5'd7, 7'h03);
    img[5]  = f_s(12'hff0, 5'd7, 5'd6, 3'b010);
    img[6]  = f_i(12'd4, 5'd5, 3'b010, 5'd7, 7'h03);
    img[7]  = f_s(12'hff4, 5'd7, 5'd6, 3'b010);
    img[8]  = f_i(pre, 5'd0, 3'd0, 5'd10, 7'h13);
    img[9]  = f_i(12'hff0 | {11'b0, odd}, 5'd6, 3'd0, 5'd1, 7'h67);
    img[10] = f_i(12'd1, 5'd0, 3'd0, 5'd17, 7'h13);
    img[11] = 32'h0000_0073;
    img[12] = 32'h0010_0073;
    img[13] = f_i(12'd10, 5'd0, 3'd0, 5'd17, 7'h13);
    img[14] = 32'h0000_0073;
    img[32] = w0;
    img[33] = 32'h0000_8067;
  endtask

  task automatic check_jit(input logic [31:0] exp, input string tag);
    chk(n_ec == 2, {tag, " R8 two calls, break ignored"}, n_ec, 32'd2);
    chk(cap_code[0] == 32'd1, {tag, " R8 first code"}, cap_code[0], 32'd1);
    chk(cap_arg[0] == exp, {tag, " R1 R7 R5 result"}, cap_arg[0], exp);
    chk(cap_code[1] == 32'd10, {tag, " R9 halt code"}, cap_code[1], 32'd10);
    chk(halt && !fault, {tag, " R9 halted cleanly"}, {30'b0, halt, fault}, 32'h2);
  endtask

  task automatic bad_at8(input logic [31:0] w, input string tag);
    fill_nop();
    img[2] = w;
    tail_at(3);
    run(1'b0);
    chk(fault && !halt, {tag, " fault set"}, {30'b0, halt, fault}, 32'h1);
    chk(fpc == 32'd8, {tag, " fault address"}, fpc, 32'd8);
    chk(n_ec == 0, {tag, " no call after fault"}, n_ec, 32'd0);
    repeat (10) @(negedge clk);
    chk(fault && fpc == 32'd8, {tag, " fault sticky"}, fpc, 32'd8);
  endtask

  initial begin
    void'($urandom(32'h1d5e_ed01));

    // three fixed words producing 42
    build_jit(32'h02a0_0513, 12'h123, 1'b0); run(1'b1); check_jit(32'd42, "add42");
    repeat (20) @(negedge clk);
    chk(halt && n_ec == 2, "R9 halt sticky, no further call", n_ec, 32'd2);
    build_jit(32'h02a0_6513, 12'h7ff, 1'b1); run(1'b0); check_jit(32'd42, "or42");
    build_jit(32'h02a0_4513, 12'h800, 1'b0); run(1'b0); check_jit(32'd42, "xor42");

    // random generated words
    for (int k = 0; k < 40; k++) begin
      logic [2:0]  f3;
      logic [11:0] imm, pre;
      logic [4:0]  src;
      bit          odd;
      case ($urandom_range(2)) 0: f3 = 3'b000; 1: f3 = 3'b100; default: f3 = 3'b110; endcase
      imm = 12'($urandom);
      pre = 12'($urandom);
      src = ($urandom_range(1) == 1) ? 5'd10 : 5'd0;
      odd = 1'($urandom_range(1));
      build_jit(f_i(imm, src, f3, 5'd10, 7'h13), pre, odd);
      run(1'b0);
      check_jit(calc(f3, (src == 5'd10) ? sx(pre) : 32'h0, sx(imm)), "rand R1");
    end

    // x0 write discarded
    fill_nop();
    img[0] = f_i(12'd77, 5'd0, 3'd0, 5'd0, 7'h13);
    img[1] = f_i(12'd5, 5'd0, 3'd0, 5'd10, 7'h13);
    tail_at(2);
    run(1'b0);
    chk(n_ec == 2 && cap_arg[0] == 32'd5, "R4 x0 still zero", cap_arg[0], 32'd5);

    // upper immediate relative to own address
    fill_nop();
    img[3] = f_u(20'h00001, 5'd10);
    tail_at(4);
    run(1'b0);
    chk(cap_arg[0] == 32'd4108, "R6 positive upper", cap_arg[0], 32'd4108);
    fill_nop();
    img[3] = f_u(20'hfffff, 5'd10);
    tail_at(4);
    run(1'b0);
    chk(cap_arg[0] == 32'hffff_f00c, "R6 negative upper", cap_arg[0], 32'hffff_f00c);

    // faults
    bad_at8(f_i(12'd1, 5'd0, 3'b010, 5'd10, 7'h13), "R2 alu funct3 010");
    bad_at8(f_i(12'd1, 5'd0, 3'b001, 5'd10, 7'h13), "R2 alu funct3 001");
    bad_at8(f_i(12'd0, 5'd0, 3'b000, 5'd10, 7'h03), "R2 byte load");
    bad_at8(f_s(12'd0, 5'd10, 5'd0, 3'b001), "R2 half store");
    bad_at8(f_i(12'd0, 5'd1, 3'b001, 5'd0, 7'h67), "R2 jump funct3");
    bad_at8(32'h00b5_0533, "R3 register-register op");
    bad_at8(32'h0000_0000, "R3 zero word");

    // code limit
    fill_nop();
    run(1'b0);
    chk(halt && !fault, "R10 halt at code end", {30'b0, halt, fault}, 32'h2);
    chk(n_ec == 0, "R10 no call at code end", n_ec, 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule